// File: doc/BRIEF.md
# Serial Shift Unit with Edge Counter

The block is a bus-accessible 8-bit shift register coupled to a 4-bit step counter. Both advance on one selectable clock source, which can be a software strobe, a timer-overflow strobe or an external serial clock pin. With the pin selected, the register shifts on one chosen edge and the counter advances on both edges, so one byte takes sixteen counts. When the counter wraps, it raises an overflow flag that marks the end of a transfer.

The register MSB drives the serial output. In three-wire mode it appears on a push-pull data output. In two-wire mode it drives a pull-low request for an open-drain data line. A level-sensitive hold stage sits between the MSB and the pins, so a pin-clocked output changes on the edge opposite the one that samples. Serial input is always taken from the DI pin.

The external pin and DI pass through a two-stage synchronizer and are edge-detected in the system clock domain. A software toggle control drives a clock output pin so that a master can produce its own edges. The bench feeds those edges back into the pin input.

Top module: `sshift_unit`

## Requirements
- R1: While reset is held, the register reads 0x00, the counter reads 0, the overflow flag is 0, `sck_o` is 0, and `do_o` and `sda_pull_o` are 0.
- R2: A bus write with `wr_sel_i`=0 loads `wr_data_i` into the shift register. A write with `wr_sel_i`=1 loads `wr_data_i[3:0]` into the counter and ignores the upper bits. Either load is readable after one clock, and a write wins over a shift or count of the same register in the same cycle.
- R3: With `clk_src_i`=0 (software), each `sw_strobe_i` cycle shifts the synchronized DI into bit 0 and adds 1 to the counter, and `tmr_ovf_i` has no effect. With `clk_src_i`=1 (timer), `tmr_ovf_i` does the same and `sw_strobe_i` has no effect.
- R4: With `clk_src_i`=2 the register shifts on rising pin edges; with `clk_src_i`=3 it shifts on falling pin edges. In both cases the counter adds 1 on every pin edge, so a full byte leaves the counter where it started.
- R5: A counter step from 15 to 0 sets the overflow flag. The flag then stays set until `ovf_clr_i` is asserted, and a wrap in the same cycle as a clear leaves the flag set.
- R6: With a pin clock selected, the serial output holds its value while the synchronized pin sits at the level after the sampling edge. It follows the register MSB only while the pin is at the opposite level.
- R7: `mode_i`=1 (three-wire) puts the held MSB on `do_o` and keeps `sda_pull_o` at 0. `mode_i`=2 (two-wire) drives `sda_pull_o` high exactly when the held MSB is 0 and keeps `do_o` at 0. `mode_i`=0 and 3 keep both outputs at 0.
- R8: Each cycle with `sw_toggle_i` high inverts `sck_o`. Those edges, fed back into `sck_i`, are counted and shifted as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Bus write strobe |
| wr_sel_i | input | 1 | Write target: 0 shift register, 1 counter |
| wr_data_i | input | 8 | Bus write data |
| rd_data_o | output | 8 | Shift register contents |
| rd_cnt_o | output | 4 | Counter contents |
| mode_i | input | 2 | Wire mode: 0 off, 1 three-wire, 2 two-wire, 3 off |
| clk_src_i | input | 2 | Clock source: 0 software, 1 timer, 2 pin rising, 3 pin falling |
| sw_strobe_i | input | 1 | Software shift/count strobe |
| sw_toggle_i | input | 1 | Inverts the clock output pin |
| tmr_ovf_i | input | 1 | Timer overflow strobe |
| sck_i | input | 1 | External serial clock pin |
| sck_o | output | 1 | Master clock output pin |
| di_i | input | 1 | Serial data input pin |
| do_o | output | 1 | Three-wire serial data output |
| sda_pull_o | output | 1 | Two-wire data line pull-low request |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| ovf_flag_o | output | 1 | Counter overflow flag |

## Verification
Bus writes and strobes take effect on the next clock edge, and DI needs two cycles to cross its synchronizer. A pin edge shifts and counts three clocks after it reaches `sck_i`, and the held output follows the pin level two clocks after the pin changes. The bench drives inputs on falling clock edges and sets DI a cycle ahead of each strobe. It waits four clocks after every pin edge before it samples, and it checks the held output both after the sampling edge and after the opposite edge.

// File: rtl/sshift_pkg.sv
package sshift_pkg;

  typedef enum logic [1:0] {
    SRC_SOFT     = 2'd0,
    SRC_TIMER    = 2'd1,
    SRC_PIN_RISE = 2'd2,
    SRC_PIN_FALL = 2'd3
  } clk_src_e;

  typedef enum logic [1:0] {
    WIRE_OFF   = 2'd0,
    WIRE_THREE = 2'd1,
    WIRE_TWO   = 2'd2,
    WIRE_RSVD  = 2'd3
  } wire_mode_e;

  typedef struct packed {
    logic shift;
    logic count;
    logic latch_open;
  } step_t;

endpackage

// File: rtl/sshift_sync.sv
module sshift_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q, chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sshift_clksel.sv
module sshift_clksel
  import sshift_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  clk_src_e src_i,
  input  logic     sw_strobe_i,
  input  logic     tmr_ovf_i,
  input  logic     pin_s_i,
  output step_t    step_o
);
  logic prev_q;
  logic pin_rise, pin_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin_s_i;
  end

  assign pin_rise = pin_s_i & ~prev_q;
  assign pin_fall = ~pin_s_i & prev_q;

  always_comb begin
    step_o = '0;
    unique case (src_i)
      SRC_SOFT: begin
        step_o.shift      = sw_strobe_i;
        step_o.count      = sw_strobe_i;
        step_o.latch_open = 1'b1;
      end
      SRC_TIMER: begin
        step_o.shift      = tmr_ovf_i;
        step_o.count      = tmr_ovf_i;
        step_o.latch_open = 1'b1;
      end
      SRC_PIN_RISE: begin
        step_o.shift      = pin_rise;
        step_o.count      = pin_rise | pin_fall;
        step_o.latch_open = ~pin_s_i;
      end
      SRC_PIN_FALL: begin
        step_o.shift      = pin_fall;
        step_o.count      = pin_rise | pin_fall;
        step_o.latch_open = pin_s_i;
      end
      default: step_o = '0;
    endcase
  end
endmodule

// File: rtl/sshift_datapath.sv
module sshift_datapath #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          shift_i,
  input  logic          latch_open_i,
  input  logic          di_s_i,
  output logic [DW-1:0] shreg_o,
  output logic          dout_o
);
  logic [DW-1:0] sr_q, sr_d;
  logic          hold_q;

  always_comb begin
    sr_d = sr_q;
    if (wr_i)         sr_d = wr_data_i;
    else if (shift_i) sr_d = {sr_q[DW-2:0], di_s_i};
  end

  // level-sensitive hold stage: passes the MSB while open, keeps it while closed
  assign dout_o = latch_open_i ? sr_q[DW-1] : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      hold_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      hold_q <= dout_o;
    end
  end

  assign shreg_o = sr_q;
endmodule

// File: rtl/sshift_counter.sv
module sshift_counter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [CW-1:0] wr_val_i,
  input  logic          count_i,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o,
  output logic          flag_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;
  logic          wrap;

  assign wrap = count_i & ~wr_i & (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (wr_i)         cnt_d = wr_val_i;
    else if (count_i) cnt_d = cnt_q + 1'b1;
    flag_d = wrap | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/sshift_unit.sv
module sshift_unit
  import sshift_pkg::*;
#(
  parameter int DW          = 8,
  parameter int CW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic          wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] rd_cnt_o,
  input  logic [1:0]    mode_i,
  input  logic [1:0]    clk_src_i,
  input  logic          sw_strobe_i,
  input  logic          sw_toggle_i,
  input  logic          tmr_ovf_i,
  input  logic          sck_i,
  output logic          sck_o,
  input  logic          di_i,
  output logic          do_o,
  output logic          sda_pull_o,
  input  logic          ovf_clr_i,
  output logic          ovf_flag_o
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;
  logic                  pin_s, di_s, dout;
  logic                  tog_q, tog_d;
  step_t                 step;
  wire_mode_e            mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  sshift_sync #(.STAGES(SYNC_STAGES)) u_sck_sync (
    .clk(clk), .rst_n(rst_int_n), .d_i(sck_i), .q_o(pin_s)
  );

  sshift_sync #(.STAGES(SYNC_STAGES)) u_di_sync (
    .clk(clk), .rst_n(rst_int_n), .d_i(di_i), .q_o(di_s)
  );

  sshift_clksel u_clksel (
    .clk(clk), .rst_n(rst_int_n), .src_i(clk_src_e'(clk_src_i)),
    .sw_strobe_i(sw_strobe_i), .tmr_ovf_i(tmr_ovf_i),
    .pin_s_i(pin_s), .step_o(step)
  );

  sshift_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_int_n),
    .wr_i(wr_en_i & ~wr_sel_i), .wr_data_i(wr_data_i),
    .shift_i(step.shift), .latch_open_i(step.latch_open),
    .di_s_i(di_s), .shreg_o(rd_data_o), .dout_o(dout)
  );

  sshift_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_int_n),
    .wr_i(wr_en_i & wr_sel_i), .wr_val_i(wr_data_i[CW-1:0]),
    .count_i(step.count), .clr_i(ovf_clr_i),
    .cnt_o(rd_cnt_o), .flag_o(ovf_flag_o)
  );

  assign tog_d = tog_q ^ sw_toggle_i;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) tog_q <= 1'b0;
    else            tog_q <= tog_d;
  end
  assign sck_o = tog_q;

  assign mode       = wire_mode_e'(mode_i);
  assign do_o       = (mode == WIRE_THREE) & dout;
  assign sda_pull_o = (mode == WIRE_TWO) & ~dout;
endmodule

// File: rtl/sshift_unit_chk.sv
module sshift_unit_chk #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en_i,
  input logic          wr_sel_i,
  input logic [DW-1:0] wr_data_i,
  input logic [DW-1:0] rd_data_o,
  input logic [CW-1:0] rd_cnt_o,
  input logic [1:0]    mode_i,
  input logic          sw_toggle_i,
  input logic          sck_o,
  input logic          do_o,
  input logic          sda_pull_o,
  input logic          ovf_clr_i,
  input logic          ovf_flag_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  // R2
  shreg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_sel_i) |=> (rd_data_o == $past(wr_data_i)));

  // R2
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i) |=> (rd_cnt_o == $past(wr_data_i[CW-1:0])));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_cnt_o) |-> ($past(wr_en_i && wr_sel_i) ||
                            rd_cnt_o == CW'($past(rd_cnt_o) + 1'b1)));

  // R5
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag_o) |-> ($past(rd_cnt_o) == CNT_MAX && rd_cnt_o == '0));

  // R5
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_flag_o) |-> $past(ovf_clr_i));

  // R7
  two_wire_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd2) |-> !do_o);

  // R7
  three_wire_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 2'd2) |-> !sda_pull_o);

  // R8
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_toggle_i |=> (sck_o != $past(sck_o)));

  // R8
  toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_toggle_i |=> $stable(sck_o));
endmodule

bind sshift_unit sshift_unit_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .rd_cnt_o(rd_cnt_o),
  .mode_i(mode_i), .sw_toggle_i(sw_toggle_i), .sck_o(sck_o),
  .do_o(do_o), .sda_pull_o(sda_pull_o), .ovf_clr_i(ovf_clr_i),
  .ovf_flag_o(ovf_flag_o)
);

// File: tb/sshift_unit_test.sv
module sshift_unit_test;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n;
  logic       wr_en, wr_sel;
  logic [7:0] wr_data, rd_data;
  logic [3:0] rd_cnt;
  logic [1:0] mode, src;
  logic       sw_strobe, sw_toggle, tmr_ovf;
  logic       sck_drv, sck_loop, sck_o, sck_pin;
  logic       di, do_o, sda_pull, ovf_clr, ovf_flag;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  assign sck_pin = sck_loop ? sck_o : sck_drv;

  sshift_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .rd_cnt_o(rd_cnt),
    .mode_i(mode), .clk_src_i(src), .sw_strobe_i(sw_strobe),
    .sw_toggle_i(sw_toggle), .tmr_ovf_i(tmr_ovf), .sck_i(sck_pin),
    .sck_o(sck_o), .di_i(di), .do_o(do_o), .sda_pull_o(sda_pull),
    .ovf_clr_i(ovf_clr), .ovf_flag_o(ovf_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input bit sel, input logic [7:0] val);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic soft_pulse(input bit d);
    di = d;
    step(3);
    sw_strobe = 1'b1;
    step(1);
    sw_strobe = 1'b0;
  endtask

  task automatic clear_flag();
    ovf_clr = 1'b1;
    step(1);
    ovf_clr = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wr_en = 0; wr_sel = 0; wr_data = 0; mode = 0; src = 0;
    sw_strobe = 0; sw_toggle = 0; tmr_ovf = 0; sck_drv = 0; sck_loop = 0;
    di = 0; ovf_clr = 0;
    step(3);
    check("R1 data", rd_data, 0);
    check("R1 count", rd_cnt, 0);
    check("R1 flag", ovf_flag, 0);
    check("R1 sck_o", sck_o, 0);
    check("R1 do_o", do_o, 0);
    check("R1 sda_pull", sda_pull, 0);
    rst_n = 1'b1;
    step(4);
  endtask

  task automatic t_write();
    bus_write(1'b0, 8'hA5);
    check("R2 shreg load", rd_data, 8'hA5);
    bus_write(1'b1, 8'h1F);
    check("R2 counter load", rd_cnt, 4'hF);
    check("R2 shreg kept", rd_data, 8'hA5);
    di = 1'b1;
    step(3);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h09; sw_strobe = 1'b1;
    step(1);
    wr_en = 1'b0; sw_strobe = 1'b0;
    check("R2 write wins count", rd_cnt, 4'h9);
    check("R2 shift same cycle", rd_data, 8'h4B);
  endtask

  task automatic t_soft();
    logic [7:0] pat = 8'b1011_0010;
    mode = 2'd2; src = 2'd0;
    bus_write(1'b0, 8'h00);
    bus_write(1'b1, 8'h00);
    for (int i = 7; i >= 0; i--) soft_pulse(pat[i]);
    check("R3 soft data", rd_data, pat);
    check("R3 soft count", rd_cnt, 8);
    tmr_ovf = 1'b1; step(1); tmr_ovf = 1'b0; step(1);
    check("R3 timer ignored data", rd_data, pat);
    check("R3 timer ignored count", rd_cnt, 8);
  endtask

  task automatic t_timer();
    src = 2'd1;
    bus_write(1'b0, 8'h00);
    bus_write(1'b1, 8'h00);
    di = 1'b1;
    step(3);
    for (int i = 0; i < 4; i++) begin
      tmr_ovf = 1'b1; step(1); tmr_ovf = 1'b0; step(1);
    end
    check("R3 timer data", rd_data, 8'h0F);
    check("R3 timer count", rd_cnt, 4);
    sw_strobe = 1'b1; step(1); sw_strobe = 1'b0; step(1);
    check("R3 soft ignored data", rd_data, 8'h0F);
    check("R3 soft ignored count", rd_cnt, 4);
  endtask

  task automatic t_pin_rise();
    logic [7:0] pat = 8'h5A;
    logic [7:0] exp = 8'hC3;
    int cnt = 0;
    logic old_msb;
    src = 2'd0; mode = 2'd1; sck_drv = 1'b0;
    step(4);
    src = 2'd2;
    bus_write(1'b0, exp);
    bus_write(1'b1, 8'h00);
    clear_flag();
    step(2);
    check("R7 three-wire do", do_o, 1);
    check("R7 three-wire sda", sda_pull, 0);
    for (int i = 7; i >= 0; i--) begin
      di = pat[i];
      step(1);
      old_msb = exp[7];
      sck_drv = 1'b1;
      step(4);
      exp = {exp[6:0], pat[i]};
      cnt = (cnt + 1) % 16;
      check("R6 held after sample edge", do_o, old_msb);
      check("R4 rise data", rd_data, exp);
      check("R4 rise count", rd_cnt, cnt);
      sck_drv = 1'b0;
      step(4);
      cnt = (cnt + 1) % 16;
      check("R6 follows after opposite edge", do_o, exp[7]);
      check("R4 fall count", rd_cnt, cnt);
    end
    check("R4 byte data", rd_data, pat);
    check("R5 flag after byte", ovf_flag, 1);
  endtask

  task automatic t_overflow();
    src = 2'd0;
    clear_flag();
    check("R5 flag cleared", ovf_flag, 0);
    bus_write(1'b1, 8'h0F);
    ovf_clr = 1'b1; sw_strobe = 1'b1;
    step(1);
    ovf_clr = 1'b0; sw_strobe = 1'b0;
    check("R5 wrap count", rd_cnt, 0);
    check("R5 set beats clear", ovf_flag, 1);
    step(2);
    check("R5 flag sticky", ovf_flag, 1);
    clear_flag();
    check("R5 flag clear", ovf_flag, 0);
  endtask

  task automatic t_pin_fall();
    src = 2'd0; sck_drv = 1'b1;
    step(4);
    src = 2'd3;
    bus_write(1'b0, 8'h00);
    bus_write(1'b1, 8'h0E);
    di = 1'b1;
    step(3);
    sck_drv = 1'b0;
    step(4);
    check("R4 fall-edge shift", rd_data, 8'h01);
    check("R4 fall-edge count", rd_cnt, 4'hF);
    sck_drv = 1'b1;
    step(4);
    check("R4 rise no shift", rd_data, 8'h01);
    check("R5 wrap on pin edge", rd_cnt, 0);
    check("R5 flag on pin wrap", ovf_flag, 1);
    clear_flag();
  endtask

  task automatic t_modes();
    src = 2'd0;
    mode = 2'd2;
    bus_write(1'b0, 8'h80);
    check("R7 two-wire release", sda_pull, 0);
    check("R7 two-wire do quiet", do_o, 0);
    bus_write(1'b0, 8'h00);
    check("R7 two-wire pull", sda_pull, 1);
    mode = 2'd0;
    step(1);
    check("R7 off sda", sda_pull, 0);
    check("R7 off do", do_o, 0);
    bus_write(1'b0, 8'hFF);
    mode = 2'd3;
    step(1);
    check("R7 reserved do", do_o, 0);
    check("R7 reserved sda", sda_pull, 0);
  endtask

  task automatic t_master();
    src = 2'd0; sck_drv = 1'b0;
    check("R8 sck_o idle", sck_o, 0);
    sck_loop = 1'b1;
    step(4);
    src = 2'd2;
    bus_write(1'b0, 8'h00);
    bus_write(1'b1, 8'h00);
    di = 1'b1;
    step(3);
    sw_toggle = 1'b1; step(1); sw_toggle = 1'b0;
    check("R8 toggle high", sck_o, 1);
    step(4);
    check("R8 looped rise shift", rd_data, 8'h01);
    check("R8 looped rise count", rd_cnt, 1);
    sw_toggle = 1'b1; step(1); sw_toggle = 1'b0;
    check("R8 toggle low", sck_o, 0);
    step(4);
    check("R8 looped fall count", rd_cnt, 2);
    check("R8 looped fall no shift", rd_data, 8'h01);
  endtask

  initial begin
    t_reset();
    t_write();
    t_soft();
    t_timer();
    t_pin_rise();
    t_overflow();
    t_pin_fall();
    t_modes();
    t_master();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule